// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds eight hardware lock flags that two independent ports, called left and right, use to claim shared resources. The flags sit apart from any shared memory. A port reaches the bank by driving its active-low semaphore select low while its memory chip enable stays high. It names a flag through the low three address bits and then either writes, using its active-low write strobe, or reads, using its active-low output enable.

A port claims a flag by writing 0 in data bit 0 and gives it up by writing 1. Each flag keeps three things: which side owns it, and whether each side has a claim waiting. A port therefore reads 0 only while it holds the flag. A claim made while the other side holds the flag waits, and it takes over in the same cycle as the release. When both sides claim a free flag in the same cycle, the left side wins and the right side's claim waits.

Each read returns the requesting side's view of the flag on every data bit. The value comes from a per-port output register that captures the flag state as it was before any write in the same cycle. The register then holds that value until the port's next read.

Top module: `sem_bank`

## Requirements
- R1: During and after synchronous reset, every flag is free with no waiting claims, and both read registers hold all ones.
- R2: A port takes part only when its semaphore select is low and its chip enable is high. A write strobe that arrives while the chip enable is low leaves every flag unchanged.
- R3: The flag is chosen by address bits 2..0, and the higher address bits are ignored. An access changes or reads only the flag it addresses.
- R4: A write looks only at data bit 0: 0 is a claim and 1 is a release. The other data bits have no effect.
- R5: A claim on a free flag makes the claiming side read 0 and the other side read 1.
- R6: A side that does not own a flag cannot release it. A write of 1 from that side only withdraws its own waiting claim. A repeated claim by the owner changes nothing.
- R7: A release by the owner, with no claim waiting from the other side, frees the flag, and both sides then read 1.
- R8: A claim made while the other side owns the flag waits. The claimant becomes owner in the same cycle as the owner's release.
- R9: When both sides claim the same free flag in one cycle, the left side owns it and the right side's claim waits. A flag never has two owners.
- R10: A read, meaning select low, chip enable high, write strobe high and output enable low, loads the port's read register with the side's view of the flag replicated across all data bits. The register is visible one cycle later, reflects the state before any same-cycle write, and holds its value while no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low, must be high for flag access |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address, bits 2..0 pick the flag |
| l_wdata | input | DATA_W | Left write data, only bit 0 used |
| l_rdata | output | DATA_W | Left read register |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low, must be high for flag access |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address, bits 2..0 pick the flag |
| r_wdata | input | DATA_W | Right write data, only bit 0 used |
| r_rdata | output | DATA_W | Right read register |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each clock edge. They also assume that a port presents at most one access per cycle, with the write strobe taking precedence over the output enable. The stimulus drives each port to exactly one of five states per cycle: idle, claim, release, blocked write with the chip enable low, or read. It changes inputs only on the falling clock edge. The sweep walks every ordered pair of these write-side actions over two consecutive cycles on every flag, and it randomises the unused address and data bits so that the ignored inputs are always exercised.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef struct packed {
        logic own_l;
        logic own_r;
        logic pend_l;
        logic pend_r;
    } flag_state_t;

    localparam flag_state_t FLAG_FREE = '0;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_TAKE = 2'd1,
        OP_GIVE = 2'd2
    } sem_op_e;

    // Exchange the roles of the two sides.
    function automatic flag_state_t swap_sides(flag_state_t s);
        flag_state_t m;
        m.own_l  = s.own_r;
        m.own_r  = s.own_l;
        m.pend_l = s.pend_r;
        m.pend_r = s.pend_l;
        return m;
    endfunction

    // Effect of one left-side operation on a flag.
    function automatic flag_state_t step_left(flag_state_t s, sem_op_e op);
        flag_state_t n = s;
        case (op)
            OP_TAKE: begin
                if (!s.own_l) begin
                    if (s.own_r) n.pend_l = 1'b1;
                    else         n.own_l  = 1'b1;
                end
            end
            OP_GIVE: begin
                if (s.own_l) begin
                    n.own_l = 1'b0;
                    if (s.pend_r) begin
                        n.own_r  = 1'b1;
                        n.pend_r = 1'b0;
                    end
                end else begin
                    n.pend_l = 1'b0;
                end
            end
            default: n = s;
        endcase
        return n;
    endfunction

    function automatic flag_state_t step_right(flag_state_t s, sem_op_e op);
        return swap_sides(step_left(swap_sides(s), op));
    endfunction

    // Left goes first, which gives it priority on same-cycle claims.
    function automatic flag_state_t step_both(flag_state_t s, sem_op_e lop, sem_op_e rop);
        return step_right(step_left(s, lop), rop);
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              sem_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output sem_op_e           op,
    output logic [IDX_W-1:0]  idx,
    output logic              rd
);
    logic sel;

    always_comb begin
        sel = !sem_n && ce_n;
        rd  = sel && we_n && !oe_n;
        idx = addr[IDX_W-1:0];
        if (sel && !we_n) op = wdata[0] ? OP_GIVE : OP_TAKE;
        else              op = OP_NONE;
    end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int FLAG_ID   = 0,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  sem_op_e          l_op,
    input  logic [IDX_W-1:0] l_idx,
    input  sem_op_e          r_op,
    input  logic [IDX_W-1:0] r_idx,
    output flag_state_t      state
);
    sem_op_e     l_here, r_here;
    flag_state_t nxt;

    always_comb begin
        l_here = (l_idx == IDX_W'(FLAG_ID)) ? l_op : OP_NONE;
        r_here = (r_idx == IDX_W'(FLAG_ID)) ? r_op : OP_NONE;
        nxt    = step_both(state, l_here, r_here);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FLAG_FREE;
        else     state <= nxt;
    end
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] view,
    output logic [DATA_W-1:0]    rdata
);
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '1;
        else if (rd) rdata <= {DATA_W{view[idx]}};
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    sem_op_e                       l_op, r_op;
    logic [IDX_W-1:0]              l_idx, r_idx;
    logic                          l_rd, r_rd;
    flag_state_t [NUM_FLAGS-1:0]   flag_q;
    logic [NUM_FLAGS-1:0]          l_view, r_view;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_l (
        .sem_n(l_sem_n), .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .addr(l_addr), .wdata(l_wdata), .op(l_op), .idx(l_idx), .rd(l_rd)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_r (
        .sem_n(r_sem_n), .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .addr(r_addr), .wdata(r_wdata), .op(r_op), .idx(r_idx), .rd(r_rd)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sem_flag_cell #(.NUM_FLAGS(NUM_FLAGS), .FLAG_ID(i)) u_cell (
            .clk(clk), .rst(rst),
            .l_op(l_op), .l_idx(l_idx),
            .r_op(r_op), .r_idx(r_idx),
            .state(flag_q[i])
        );
        assign l_view[i] = ~flag_q[i].own_l;
        assign r_view[i] = ~flag_q[i].own_r;
    end

    sem_read_reg #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_rreg_l (
        .clk(clk), .rst(rst), .rd(l_rd), .idx(l_idx), .view(l_view), .rdata(l_rdata)
    );

    sem_read_reg #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_rreg_r (
        .clk(clk), .rst(rst), .rd(r_rd), .idx(r_idx), .view(r_view), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        l_sem_n,
    input logic                        l_ce_n,
    input logic                        l_we_n,
    input logic                        l_oe_n,
    input logic                        r_sem_n,
    input logic                        r_ce_n,
    input logic                        r_we_n,
    input logic                        r_oe_n,
    input flag_state_t [NUM_FLAGS-1:0] flags,
    input logic [DATA_W-1:0]           l_rdata,
    input logic [DATA_W-1:0]           r_rdata
);
    logic l_wr_acc, r_wr_acc, l_rd_acc, r_rd_acc;
    assign l_wr_acc = !l_sem_n && l_ce_n && !l_we_n;
    assign r_wr_acc = !r_sem_n && r_ce_n && !r_we_n;
    assign l_rd_acc = !l_sem_n && l_ce_n && l_we_n && !l_oe_n;
    assign r_rd_acc = !r_sem_n && r_ce_n && r_we_n && !r_oe_n;

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (flags == '0 && l_rdata == '1 && r_rdata == '1)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst) (!l_wr_acc && !r_wr_acc) |=> $stable(flags)); // R2
    AST_L_SOLID:     assert property (@(posedge clk) disable iff (rst) (l_rdata == '0 || l_rdata == '1)); // R10
    AST_R_SOLID:     assert property (@(posedge clk) disable iff (rst) (r_rdata == '0 || r_rdata == '1)); // R10
    AST_L_HOLD:      assert property (@(posedge clk) disable iff (rst) !l_rd_acc |=> $stable(l_rdata)); // R10
    AST_R_HOLD:      assert property (@(posedge clk) disable iff (rst) !r_rd_acc |=> $stable(r_rdata)); // R10

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
        AST_ONE_OWNER:  assert property (@(posedge clk) disable iff (rst) !(flags[i].own_l && flags[i].own_r)); // R9
        AST_L_WAIT_OWN: assert property (@(posedge clk) disable iff (rst) flags[i].pend_l |-> flags[i].own_r); // R8
        AST_R_WAIT_OWN: assert property (@(posedge clk) disable iff (rst) flags[i].pend_r |-> flags[i].own_l); // R8
    end
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .flags(flag_q), .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
    localparam int AW = 14;
    localparam int DW = 16;
    localparam int NF = 8;

    localparam int OP_IDLE  = 0;
    localparam int OP_TAKE  = 1;
    localparam int OP_GIVE  = 2;
    localparam int OP_BLOCK = 3;
    localparam int OP_READ  = 4;

    logic clk = 1'b0;
    logic rst;
    logic l_sem_n, l_ce_n, l_we_n, l_oe_n;
    logic r_sem_n, r_ce_n, r_we_n, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit m_ol[NF], m_or[NF], m_pl[NF], m_pr[NF];

    always #2 clk = ~clk;

    sem_bank #(.ADDR_W(AW), .DATA_W(DW), .NUM_FLAGS(NF)) u_sem_bank (
        .clk(clk), .rst(rst),
        .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_side(input bit left, input int op, input int f, input int salt);
        logic sn, cn, wn, on;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = AW'((salt * 13 + 7) << 3) | AW'(f);
        d = DW'((salt * 37 + 5) << 1);
        sn = 1'b1; cn = 1'b1; wn = 1'b1; on = 1'b1;
        case (op)
            OP_TAKE:  begin sn = 1'b0; wn = 1'b0; end
            OP_GIVE:  begin sn = 1'b0; wn = 1'b0; d[0] = 1'b1; end
            OP_BLOCK: begin sn = 1'b0; cn = 1'b0; wn = 1'b0; end
            OP_READ:  begin sn = 1'b0; on = 1'b0; d[0] = 1'b1; end
            default:  ;
        endcase
        if (left) begin
            l_sem_n = sn; l_ce_n = cn; l_we_n = wn; l_oe_n = on; l_addr = a; l_wdata = d;
        end else begin
            r_sem_n = sn; r_ce_n = cn; r_we_n = wn; r_oe_n = on; r_addr = a; r_wdata = d;
        end
    endtask

    // Reference behaviour derived from R5..R9, applied left first.
    task automatic model_apply(input bit left, input int op, input int f);
        if (left) begin
            if (op == OP_TAKE && !m_ol[f]) begin
                if (m_or[f]) m_pl[f] = 1'b1; else m_ol[f] = 1'b1;
            end else if (op == OP_GIVE) begin
                if (m_ol[f]) begin
                    m_ol[f] = 1'b0;
                    if (m_pr[f]) begin m_or[f] = 1'b1; m_pr[f] = 1'b0; end
                end else m_pl[f] = 1'b0;
            end
        end else begin
            if (op == OP_TAKE && !m_or[f]) begin
                if (m_ol[f]) m_pr[f] = 1'b1; else m_or[f] = 1'b1;
            end else if (op == OP_GIVE) begin
                if (m_or[f]) begin
                    m_or[f] = 1'b0;
                    if (m_pl[f]) begin m_ol[f] = 1'b1; m_pl[f] = 1'b0; end
                end else m_pr[f] = 1'b0;
            end
        end
    endtask

    task automatic read_check(input int f, input int salt, input string req);
        @(negedge clk);
        set_side(1'b1, OP_READ, f, salt);
        set_side(1'b0, OP_READ, f, salt + 3);
        @(negedge clk);
        set_side(1'b1, OP_IDLE, 0, 0);
        set_side(1'b0, OP_IDLE, 0, 0);
        check({req, " left view"},  l_rdata, {DW{~m_ol[f]}});
        check({req, " right view"}, r_rdata, {DW{~m_or[f]}});
    endtask

    task automatic step(input int lop, input int rop, input int f, input int salt, input string req);
        @(negedge clk);
        set_side(1'b1, lop, f, salt);
        set_side(1'b0, rop, f, salt + 1);
        model_apply(1'b1, lop, f);
        model_apply(1'b0, rop, f);
        read_check(f, salt, req);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_side(1'b1, OP_IDLE, 0, 0);
        set_side(1'b0, OP_IDLE, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: read registers start at all ones, all flags free
        check("R1 reset left rdata", l_rdata, '1);
        check("R1 reset right rdata", r_rdata, '1);
        for (int f = 0; f < NF; f++) read_check(f, f, "R1 free after reset");

        // Sweep: every pair of write-side actions over two cycles per flag.
        // R2 blocked writes, R3 random high address bits, R4 random high data bits
        for (int f = 0; f < NF; f++) begin
            for (int s = 0; s < 256; s++) begin
                step(s & 3, (s >> 2) & 3, f, s, "R2 R3 R4 R5 R6 R7 R8 R9 sweep");
                step((s >> 4) & 3, (s >> 6) & 3, f, s + 100, "R2 R3 R4 R5 R6 R7 R8 R9 sweep");
            end
            for (int g = 0; g < NF; g++) read_check(g, g + f, "R3 flag isolation");
        end

        // R9: same-cycle claims on a free flag
        step(OP_GIVE, OP_GIVE, 3, 11, "R7 release to free");
        check("R7 model free", {15'd0, m_ol[3] | m_or[3]}, 16'd0);
        step(OP_TAKE, OP_TAKE, 3, 12, "R9 left wins tie");
        check("R9 left owns", {15'd0, m_ol[3]}, 16'd1);
        // R8: waiting right claim takes over on release
        step(OP_GIVE, OP_IDLE, 3, 13, "R8 handover to right");
        step(OP_TAKE, OP_IDLE, 3, 14, "R8 left waits");

        // R10: read in the same cycle as the release sees the old view
        @(negedge clk);
        set_side(1'b1, OP_READ, 3, 15);
        set_side(1'b0, OP_GIVE, 3, 16);
        model_apply(1'b0, OP_GIVE, 3);
        @(negedge clk);
        set_side(1'b1, OP_IDLE, 0, 0);
        set_side(1'b0, OP_TAKE, 3, 17);
        model_apply(1'b0, OP_TAKE, 3);
        check("R10 pre-write view", l_rdata, '1);
        @(negedge clk);
        set_side(1'b0, OP_IDLE, 0, 0);
        check("R10 register holds", l_rdata, '1);
        read_check(3, 18, "R10 R8 new owner left");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule